// File: doc/BRIEF.md
# SPI Master Word Buffer with Register Port

This block connects a small synchronous register port to an SPI master output stage. Software writes a data word into a single transmit buffer, and that word waits there until the serial shifter is free. Each finished frame places the received word into a single receive buffer. A status register reports three conditions: the transmit buffer is free, the receive buffer holds a word, and a received word was lost. The serial side always runs in mode 0. The clock rests low, the slave is sampled on the rising edge, frames go out most significant bit first, and a select line is held low for the length of each frame. A configuration bit chooses 8-bit or 16-bit frames.

A data write only counts if a status read came first and that read saw the transmit buffer free. Any other data write is thrown away without effect. In 16-bit mode the data register is reached one byte at a time. Two byte writes are gathered and move into the transmit buffer together as one word. Reading either received byte freezes the whole received word, so the two halves come from the same frame.

The shift engine is a four-state machine:
- IDLE → LOW happens when a word is waiting.
- LOW → HIGH happens after CLK_HALF cycles, and the MISO bit is captured at that step.
- HIGH → LOW happens after CLK_HALF cycles when more bits remain, and the next MOSI bit is presented.
- HIGH → DONE happens after the last bit.
- DONE → IDLE takes one cycle, during which the received word is delivered.

Top module: `spi_word_port`

## Requirements
- R1: After reset, a status read returns 0x01, sclk is low and ss_n is high. The status bits are: bit0 transmit free, bit1 receive full, bit2 overrun.
- R2: The address map is 0 status (read only), 1 configuration (bit0 = 16-bit mode), 2 data low byte, 3 data high byte. Read data is registered and appears on the cycle after the read strobe.
- R3: A data write made without a prior status read that saw bit0 set is dropped, and no frame starts.
- R4: A status read that sees bit0 clear disarms writing. Loading a word into the transmit buffer also disarms writing.
- R5: A word in the transmit buffer starts shifting as soon as the engine is idle. A word written during a frame follows it, with ss_n high for exactly one cycle between the two frames.
- R6: Frames are mode 0 and MSB first. ss_n is low for 2*CLK_HALF*bits+1 cycles. sclk is low whenever ss_n is high.
- R7: Receive full sets at the end of a frame. Reading the data clears it: in 8-bit mode by reading the low byte, in 16-bit mode by completing a byte pair.
- R8: If a frame ends while receive full is still set, overrun sets, the new word is discarded and the old word is kept. A status read followed by a data read clears overrun.
- R9: In 8-bit mode the high data byte reads as 0. Writes to the high data byte are ignored and do not disarm writing.
- R10: In 16-bit mode, reading one received byte freezes the whole word. Receive full stays set until the other byte has been read.
- R11: In 16-bit mode a single byte write starts no frame. The second byte completes the word, which is then sent as byte3:byte2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| spi_sclk | output | 1 | Serial clock, rests low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | 1 | Slave select, active low during a frame |

## Verification
Read data is due one cycle after the read strobe. The bench raises the strobe at a falling edge and samples bus_rdata at the next falling edge. A frame begins two edges after the accepted write: the first edge fills the transmit buffer and the second starts the engine. From then ss_n stays low for 2*CLK_HALF*bits+1 cycles, and the bench counts these cycles at falling clock edges. Status and receive checks are issued only after a fixed wait that is longer than that window. This means every flag is judged after its setting edge and never during one.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [1:0] A_STAT = 2'd0;
    localparam logic [1:0] A_CFG  = 2'd1;
    localparam logic [1:0] A_DLO  = 2'd2;
    localparam logic [1:0] A_DHI  = 2'd3;

    typedef enum logic [1:0] {
        E_IDLE,
        E_LOW,
        E_HIGH,
        E_DONE
    } eng_state_t;
endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_word_pkg::*;
#(
    parameter int CLK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    output logic              ss_n
);
    localparam int CNT_W = $clog2(CLK_HALF + 1);
    localparam int BIT_W = $clog2(DATA_W + 1);

    eng_state_t        state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bits_left;
    logic [DATA_W-1:0] tx_sh, rx_sh;
    logic              wide_q;
    logic              tick_end, last_bit;

    assign tick_end = (cnt == CNT_W'(CLK_HALF - 1));
    assign last_bit = (bits_left == BIT_W'(1));

    always_comb begin
        nxt = state;
        unique case (state)
            E_IDLE: if (start) nxt = E_LOW;
            E_LOW:  if (tick_end) nxt = E_HIGH;
            E_HIGH: if (tick_end) nxt = last_bit ? E_DONE : E_LOW;
            E_DONE: nxt = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= E_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            bits_left <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            wide_q    <= 1'b0;
        end else begin
            cnt <= (state != nxt || state == E_IDLE) ? '0 : cnt + 1'b1;
            if (state == E_IDLE && start) begin
                tx_sh     <= wide ? tx_word : {tx_word[BYTE_W-1:0], {BYTE_W{1'b0}}};
                rx_sh     <= '0;
                bits_left <= wide ? BIT_W'(DATA_W) : BIT_W'(BYTE_W);
                wide_q    <= wide;
            end
            if (state == E_LOW && tick_end)
                rx_sh <= {rx_sh[DATA_W-2:0], miso};
            if (state == E_HIGH && tick_end && !last_bit) begin
                tx_sh     <= {tx_sh[DATA_W-2:0], 1'b0};
                bits_left <= bits_left - 1'b1;
            end
        end
    end

    always_comb begin
        busy    = (state != E_IDLE);
        done    = (state == E_DONE);
        sclk    = (state == E_HIGH);
        ss_n    = (state == E_IDLE);
        mosi    = (state != E_IDLE) && tx_sh[DATA_W-1];
        rx_word = wide_q ? rx_sh : {{BYTE_W{1'b0}}, rx_sh[BYTE_W-1:0]};
    end
endmodule

// File: rtl/spi_tx_pair.sv
module spi_tx_pair
    import spi_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic              pair_done,
    output logic [DATA_W-1:0] pair_word
);
    logic [BYTE_W-1:0] lo_q, hi_q;
    logic              got_lo, got_hi;

    assign pair_done = (wr_lo && got_hi) || (wr_hi && got_lo);
    assign pair_word = {wr_hi ? wdata : hi_q, wr_lo ? wdata : lo_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            got_lo <= 1'b0;
            got_hi <= 1'b0;
        end else if (clr || pair_done) begin
            got_lo <= 1'b0;
            got_hi <= 1'b0;
        end else begin
            if (wr_lo) begin lo_q <= wdata; got_lo <= 1'b1; end
            if (wr_hi) begin hi_q <= wdata; got_hi <= 1'b1; end
        end
    end
endmodule

// File: rtl/spi_word_port.sv
module spi_word_port
    import spi_word_pkg::*;
#(
    parameter int CLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_ss_n
);
    logic              wide, armed;
    logic              tx_full, rx_full, ovr, ovr_seen;
    logic [DATA_W-1:0] tx_buf, rx_buf, hold_word, load_word;
    logic              hold, pend_hi;
    logic              eng_busy, eng_done, start;
    logic [DATA_W-1:0] eng_rx, pair_word;
    logic              pair_done, wr_ok, load8, load_tx;
    logic              stat_rd, data_rd, consumed;
    logic [7:0]        rd_val;

    assign stat_rd  = bus_rd && bus_addr == A_STAT;
    assign wr_ok    = bus_wr && armed;
    assign load8    = wr_ok && !wide && bus_addr == A_DLO;
    assign load_tx  = load8 || pair_done;
    assign load_word = wide ? pair_word : {8'h00, bus_wdata};
    assign start    = tx_full && !eng_busy;
    assign data_rd  = bus_rd && (bus_addr == A_DLO || (bus_addr == A_DHI && wide));
    assign consumed = wide ? (data_rd && hold && ((bus_addr == A_DHI) == pend_hi))
                           : (bus_rd && bus_addr == A_DLO);

    spi_tx_pair u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (bus_wr && bus_addr == A_CFG),
        .wr_lo     (wr_ok && wide && bus_addr == A_DLO),
        .wr_hi     (wr_ok && wide && bus_addr == A_DHI),
        .wdata     (bus_wdata),
        .pair_done (pair_done),
        .pair_word (pair_word)
    );

    spi_shift_engine #(.CLK_HALF(CLK_HALF)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .wide    (wide),
        .tx_word (tx_buf),
        .miso    (spi_miso),
        .busy    (eng_busy),
        .done    (eng_done),
        .rx_word (eng_rx),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .ss_n    (spi_ss_n)
    );

    always_comb begin
        unique case (bus_addr)
            A_STAT: rd_val = {5'b0, ovr, rx_full, !tx_full};
            A_CFG:  rd_val = {7'b0, wide};
            A_DLO:  rd_val = (wide && hold) ? hold_word[7:0] : rx_buf[7:0];
            A_DHI:  rd_val = !wide ? 8'h00 : (hold ? hold_word[15:8] : rx_buf[15:8]);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            wide      <= 1'b0;
            armed     <= 1'b0;
            tx_full   <= 1'b0;
            tx_buf    <= '0;
            rx_full   <= 1'b0;
            rx_buf    <= '0;
            ovr       <= 1'b0;
            ovr_seen  <= 1'b0;
            hold      <= 1'b0;
            hold_word <= '0;
            pend_hi   <= 1'b0;
        end else begin
            if (bus_rd) bus_rdata <= rd_val;
            if (bus_wr && bus_addr == A_CFG) wide <= bus_wdata[0];

            if (stat_rd)      armed <= !tx_full;
            else if (load_tx) armed <= 1'b0;

            if (load_tx) begin
                tx_buf  <= load_word;
                tx_full <= 1'b1;
            end else if (start) begin
                tx_full <= 1'b0;
            end

            if (wide && data_rd) begin
                if (!hold) begin
                    hold      <= 1'b1;
                    hold_word <= rx_buf;
                    pend_hi   <= (bus_addr == A_DLO);
                end else if (consumed) begin
                    hold <= 1'b0;
                end
            end

            if (eng_done && (!rx_full || consumed)) begin
                rx_buf  <= eng_rx;
                rx_full <= 1'b1;
            end else if (consumed) begin
                rx_full <= 1'b0;
            end

            if (stat_rd) ovr_seen <= ovr;
            if (eng_done && rx_full && !consumed) begin
                ovr <= 1'b1;
            end else if (data_rd && ovr_seen) begin
                ovr      <= 1'b0;
                ovr_seen <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_word_port_chk.sv
module spi_word_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [7:0]  bus_rdata,
    input logic        spi_sclk,
    input logic        spi_ss_n,
    input logic        wide,
    input logic        armed,
    input logic        tx_full,
    input logic        rx_full,
    input logic        ovr,
    input logic [15:0] rx_buf,
    input logic        eng_done
);
    p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_ss_n |-> !spi_sclk);

    p_drop_unarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !armed && !tx_full) |=> !tx_full);

    p_disarm_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0 && tx_full) |=> !armed);

    p_overrun_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && rx_full && !bus_rd) |=> (ovr && $stable(rx_buf)));

    p_high_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd3 && !wide) |=> (bus_rdata == 8'h00));

    p_full_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(eng_done));
endmodule

bind spi_word_port spi_word_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .spi_sclk  (spi_sclk),
    .spi_ss_n  (spi_ss_n),
    .wide      (wide),
    .armed     (armed),
    .tx_full   (tx_full),
    .rx_full   (rx_full),
    .ovr       (ovr),
    .rx_buf    (rx_buf),
    .eng_done  (eng_done)
);

// File: tb/sim_spi_word_port.sv
`timescale 1ns/1ps
module sim_spi_word_port;
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_sclk, spi_mosi, spi_miso, spi_ss_n;

    int n_checks = 0;
    int n_errors = 0;
    int frames = 0;
    int run_len = 0;
    int last_low = 0;
    logic        slv_wide = 1'b0;
    logic [15:0] sl_sh = '0;
    logic [15:0] sl_cap = '0;

    always #2.5 clk = ~clk;

    spi_word_port #(.CLK_HALF(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_ss_n(spi_ss_n)
    );

    function automatic logic [15:0] reply(input int k);
        return 16'hC3A5 ^ (16'(k) * 16'h1111);
    endfunction

    assign spi_miso = slv_wide ? sl_sh[15] : sl_sh[7];

    always @(negedge spi_ss_n) begin
        sl_sh  = reply(frames);
        sl_cap = '0;
        frames = frames + 1;
    end
    always @(negedge spi_sclk) if (!spi_ss_n) sl_sh = {sl_sh[14:0], 1'b0};
    always @(posedge spi_sclk) sl_cap = {sl_cap[14:0], spi_mosi};

    always @(negedge clk) begin
        if (!spi_ss_n) run_len++;
        else if (run_len != 0) begin last_low = run_len; run_len = 0; end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic arm();
        logic [7:0] v;
        for (int i = 0; i < 20; i++) begin
            bus_read(2'd0, v);
            if (v[0]) break;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_pins();
        check("R1 sclk", spi_sclk, 0);
        check("R1 ss_n", spi_ss_n, 1);
    endtask

    task automatic t_drop_unarmed();
        logic [7:0] v;
        int f0 = frames;
        bus_write(2'd2, 8'h77);
        idle(60);
        check("R3 no frame", frames - f0, 0);
        bus_read(2'd0, v);
        check("R1 status", v, 8'h01);
    endtask

    task automatic t_byte_frame();
        logic [7:0] v;
        int k = frames;
        arm();
        bus_write(2'd3, 8'hFF);
        bus_write(2'd2, 8'h6C);
        idle(100);
        check("R9 high write kept arm", frames - k, 1);
        check("R6 mosi msb first", sl_cap[7:0], 8'h6C);
        check("R6 select length", last_low, 2 * HALF * 8 + 1);
        bus_read(2'd0, v);
        check("R7 full set", v, 8'h03);
        bus_read(2'd1, v);
        check("R2 config", v, 8'h00);
        bus_read(2'd3, v);
        check("R9 high reads zero", v, 8'h00);
        bus_read(2'd2, v);
        check("R7 rx byte", v, reply(k) & 16'h00FF);
        bus_read(2'd0, v);
        check("R7 full cleared", v, 8'h01);
    endtask

    task automatic t_queue_overrun();
        logic [7:0] v;
        int k = frames;
        arm();
        bus_write(2'd2, 8'h81);
        arm();
        bus_write(2'd2, 8'h42);
        bus_read(2'd0, v);
        check("R4 buffer busy", v[0], 0);
        bus_write(2'd2, 8'h99);
        idle(150);
        check("R5 two frames", frames - k, 2);
        check("R5 gap", last_low, 2 * HALF * 8 + 1);
        check("R4 third dropped", sl_cap[7:0], 8'h42);
        bus_read(2'd0, v);
        check("R8 overrun set", v, 8'h07);
        bus_read(2'd2, v);
        check("R8 old word kept", v, reply(k) & 16'h00FF);
        bus_read(2'd0, v);
        check("R8 overrun cleared", v, 8'h01);
    endtask

    task automatic t_word_frame();
        logic [7:0] v;
        int k;
        slv_wide = 1'b1;
        bus_write(2'd1, 8'h01);
        k = frames;
        arm();
        bus_write(2'd3, 8'hBE);
        idle(20);
        check("R11 half word waits", frames - k, 0);
        bus_write(2'd2, 8'hEF);
        idle(120);
        check("R11 word sent", sl_cap, 16'hBEEF);
        check("R6 wide length", last_low, 2 * HALF * 16 + 1);
        bus_read(2'd3, v);
        check("R10 high byte", v, reply(k) >> 8);
        bus_read(2'd0, v);
        check("R10 still full", v, 8'h03);
        bus_read(2'd2, v);
        check("R10 low byte", v, reply(k) & 16'h00FF);
        bus_read(2'd0, v);
        check("R10 pair done", v, 8'h01);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset_pins();
        t_drop_unarmed();
        t_byte_frame();
        t_queue_overrun();
        t_word_frame();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule